// File: doc/BRIEF.md
# Quarter-Rate Weighted I/Q Mixer

This block turns a stream of real, signed intermediate-frequency samples into baseband in-phase (I) and quadrature (Q) values. The input is taken at four times the IF. At that rate the carrier phases repeat every four samples, so mixing reduces to a fixed set of signed integer weights, with FIR smoothing folded into those weights. The block needs no oscillator and no general multipliers. Samples at even positions in a window feed I and samples at odd positions feed Q. This places the Q pattern one sample behind the I pattern.

Samples arrive with a valid strobe. A mode input picks a short 4-sample window or a long 8-sample window. Windows are back to back and never overlap. After each complete window the block presents one I/Q pair together with a one-cycle valid pulse. Each weight is built from shifts and adds, and the accumulators are wide enough to hold the worst-case sum.

Top module: `quad_mixer`

## Requirements
- R1: While reset is asserted and until the first window completes, `o_valid` is 0 and `o_i` and `o_q` are 0.
- R2: Short mode (`i_long`=0): the accepted samples of a window are s0 to s3 in arrival order, and `o_i` = s0 − 3·s2.
- R3: Short mode: `o_q` = 3·s1 − s3.
- R4: Long mode (`i_long`=1): the accepted samples are s0 to s7, and `o_i` = s0 − 11·s2 + 15·s4 − 5·s6.
- R5: Long mode: `o_q` = 5·s1 − 15·s3 + 11·s5 − s7.
- R6: `o_valid` is high for exactly the one cycle after the clock edge that accepts the last sample of a window. It is low at all other times. Windows do not overlap.
- R7: A cycle with `i_valid`=0 has no effect, whatever the value on `i_sample`.
- R8: The mode is taken from `i_long` on the clock edge that accepts the first sample of a window. Changes to `i_long` later in the same window have no effect on that window.
- R9: `o_i` and `o_q` keep their values between valid pulses.
- R10: Full-scale inputs give exact results with no wrap. With 12-bit inputs and 18-bit outputs, the long-mode extremes are ±65520.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Sample strobe |
| i_sample | input | IN_W (12) | Two's-complement IF sample |
| i_long | input | 1 | 1 selects the 8-sample window, 0 the 4-sample window |
| o_valid | output | 1 | One-cycle pulse when a result pair is ready |
| o_i | output | OUT_W (18) | In-phase result, two's complement |
| o_q | output | OUT_W (18) | Quadrature result, two's complement |

## Verification
The bench uses the default widths, 12-bit samples and 18-bit results. At this size every window position can be driven across the full input range: every other code in short mode and every sixteenth code in long mode, with pseudo-random values at the other positions. Together with hand-built full-scale windows, this exercises every weight sign and the exact accumulator headroom. Further windows add idle gaps carrying garbage data and flip the mode input mid-window, to show that both are ignored.

// File: rtl/quad_mixer.sv
module quad_mixer #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    i_valid,
  input  logic [IN_W-1:0]         i_sample,
  input  logic                    i_long,
  output logic                    o_valid,
  output logic signed [OUT_W-1:0] o_i,
  output logic signed [OUT_W-1:0] o_q
);
  localparam int CNT_W = 3;

  logic [CNT_W-1:0]        cnt;
  logic                    long_q;
  logic signed [OUT_W-1:0] acc_i, acc_q, x, prod;

  wire             long_now = (cnt == '0) ? i_long : long_q;
  wire [CNT_W-1:0] last     = long_now ? CNT_W'(7) : CNT_W'(3);
  wire             odd_pos  = cnt[0];

  assign x = {{(OUT_W-IN_W){i_sample[IN_W-1]}}, i_sample};

  always_comb begin
    case ({long_now, cnt})
      4'b0_000: prod = x;
      4'b0_001: prod = (x <<< 1) + x;
      4'b0_010: prod = -((x <<< 1) + x);
      4'b0_011: prod = -x;
      4'b1_000: prod = x;
      4'b1_001: prod = (x <<< 2) + x;
      4'b1_010: prod = -((x <<< 3) + (x <<< 1) + x);
      4'b1_011: prod = -((x <<< 4) - x);
      4'b1_100: prod = (x <<< 4) - x;
      4'b1_101: prod = (x <<< 3) + (x <<< 1) + x;
      4'b1_110: prod = -((x <<< 2) + x);
      4'b1_111: prod = -x;
      default:  prod = '0;
    endcase
  end

  wire signed [OUT_W-1:0] sum_i = acc_i + (odd_pos ? '0 : prod);
  wire signed [OUT_W-1:0] sum_q = acc_q + (odd_pos ? prod : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      long_q  <= 1'b0;
      acc_i   <= '0;
      acc_q   <= '0;
      o_valid <= 1'b0;
      o_i     <= '0;
      o_q     <= '0;
    end else begin
      o_valid <= 1'b0;
      if (i_valid) begin
        if (cnt == '0) long_q <= i_long;
        if (cnt == last) begin
          o_i     <= sum_i;
          o_q     <= sum_q;
          o_valid <= 1'b1;
          acc_i   <= '0;
          acc_q   <= '0;
          cnt     <= '0;
        end else begin
          acc_i <= sum_i;
          acc_q <= sum_q;
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |=> !o_valid);
  a_r6_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(i_valid));
  a_r6_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (cnt == '0));
  a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> ($stable(o_i) && $stable(o_q)));
  a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0) |-> $stable(long_q));
endmodule

// File: tb/quad_mixer_tb.sv
module quad_mixer_tb;
  logic clk = 0, rst_n = 0, i_valid = 0, i_long = 0;
  logic [11:0] i_sample = '0;
  logic o_valid;
  logic signed [17:0] o_i, o_q;
  int checks = 0, fails = 0;
  bit done = 0;

  quad_mixer u_dut (.clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sample(i_sample),
                    .i_long(i_long), .o_valid(o_valid), .o_i(o_i), .o_q(o_q));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wt(bit lng, int k);
    if (!lng) case (k) 0: return 1; 1: return 3; 2: return -3; default: return -1; endcase
    case (k)
      0: return 1;   1: return 5;   2: return -11; 3: return -15;
      4: return 15;  5: return 11;  6: return -5;  default: return -1;
    endcase
  endfunction

  // gap: idle cycles with garbage before each sample; flip: toggle i_long after first sample
  task automatic run_window(bit lng, int s[8], bit gap, bit flip);
    int n = lng ? 8 : 4;
    int ei = 0, eq = 0;
    for (int k = 0; k < n; k++) begin
      if (k[0]) eq += wt(lng, k) * s[k]; else ei += wt(lng, k) * s[k];
    end
    for (int k = 0; k < n; k++) begin
      if (gap) begin
        @(negedge clk); i_valid = 0; i_sample = 12'($urandom);
        chk("R7 idle no pulse", int'(o_valid), 0);
      end
      @(negedge clk);
      chk("R6 no pulse mid-window", int'(o_valid), 0);
      i_valid = 1; i_sample = 12'(s[k]);
      i_long = (flip && k > 0) ? ~lng : lng;
    end
    @(negedge clk); i_valid = 0; i_sample = 12'($urandom); i_long = lng;
    chk("R6 pulse after last sample", int'(o_valid), 1);
    chk(lng ? "R4 long I" : "R2 short I", int'(o_i), ei);
    chk(lng ? "R5 long Q" : "R3 short Q", int'(o_q), eq);
    @(negedge clk);
    chk("R6 pulse one cycle", int'(o_valid), 0);
    chk("R9 I held", int'(o_i), ei);
    chk("R9 Q held", int'(o_q), eq);
  endtask

  function automatic int rnd();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  initial begin
    int s[8];
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(o_valid), 0);
    chk("R1 reset I", int'(o_i), 0);
    chk("R1 reset Q", int'(o_q), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle valid", int'(o_valid), 0);
    chk("R1 idle I", int'(o_i), 0);
    // R2 R3 sweep each short-window position over the input range
    for (int k = 0; k < 4; k++)
      for (int v = -2048; v < 2048; v += 2) begin
        for (int j = 0; j < 8; j++) s[j] = rnd();
        s[k] = v;
        run_window(0, s, 0, 0);
      end
    // R4 R5 sweep each long-window position
    for (int k = 0; k < 8; k++)
      for (int v = -2048; v < 2048; v += 16) begin
        for (int j = 0; j < 8; j++) s[j] = rnd();
        s[k] = v;
        run_window(1, s, 0, 0);
      end
    // R10 full-scale extremes, both signs, both modes
    for (int m = 0; m < 2; m++)
      for (int sg = 0; sg < 2; sg++) begin
        for (int j = 0; j < 8; j++)
          s[j] = ((wt(m[0], j) > 0) ^ sg[0]) ? 2047 : -2048;
        run_window(m[0], s, 0, 0);
      end
    for (int j = 0; j < 8; j++) s[j] = ((wt(1, j) > 0)) ? 2047 : -2048;
    run_window(1, s, 0, 0);
    chk("R10 long I max", int'(o_i), 65520);
    // R7 gaps and R8 mid-window mode flips
    for (int t = 0; t < 40; t++) begin
      for (int j = 0; j < 8; j++) s[j] = rnd();
      run_window(t[0], s, 1, t[1]);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule